// File: doc/BRIEF.md
# Three-State Power Mode Controller

This block steps a processor core between three power modes: RUN (fully working), IDLE (core stopped, interrupts still watched) and SLEEP (on-chip activity shut down). Software may ask for IDLE or SLEEP while the core runs. From IDLE, an interrupt brings the core back to RUN. Software may also ask for SLEEP while in IDLE. A separate wake input is the only way out of SLEEP, and it always leads to RUN.

Every edge of the mode graph has its own latency, set by a parameter in clock cycles. The latencies are far apart: a return from IDLE is short and a return from SLEEP is very long. While a latency runs, the block raises a busy flag and shows the destination mode. It keeps the reported mode, the power code and the stopped core clock until the count runs out. The core clock-enable and a 2-bit power code follow the reported mode.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, mode_o is RUN, target_o is RUN, busy_o is 0, core_clk_en_o is 1 and pwr_lvl_o is 2.
- R2: In RUN with no transition running, req_sleep_i starts a move to SLEEP of LAT_RUN_SLEEP cycles. Otherwise req_idle_i starts a move to IDLE of LAT_RUN_IDLE cycles. When both are high, SLEEP wins.
- R3: In IDLE with no transition running, irq_i starts a move to RUN of LAT_IDLE_RUN cycles. Otherwise req_sleep_i starts a move to SLEEP of LAT_IDLE_SLEEP cycles. When both are high, the interrupt wins.
- R4: In SLEEP, only wake_i starts a transition. It always goes to RUN and takes LAT_SLEEP_RUN cycles. irq_i, req_idle_i and req_sleep_i have no effect in SLEEP.
- R5: A request sampled at clock edge k sets busy_o after edge k. mode_o and pwr_lvl_o take the new values after edge k+L, where L is the latency of that edge. busy_o falls at the same edge.
- R6: While busy_o is high, mode_o and pwr_lvl_o keep their old values and target_o shows the destination. Every request, interrupt and wake input is ignored.
- R7: core_clk_en_o is high only when mode_o is RUN and busy_o is low. It stays low for the whole of every transition, including transitions into RUN.
- R8: Mode encoding is RUN=0, IDLE=1, SLEEP=2. The power code on pwr_lvl_o is 2 in RUN, 1 in IDLE and 0 in SLEEP.
- R9: wake_i has no effect in RUN or IDLE. irq_i has no effect in RUN. req_idle_i has no effect in IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_idle_i | input | 1 | Software request to enter IDLE |
| req_sleep_i | input | 1 | Software request to enter SLEEP |
| irq_i | input | 1 | Pending interrupt; leaves IDLE |
| wake_i | input | 1 | Wake event; leaves SLEEP |
| mode_o | output | 2 | Current mode (RUN=0, IDLE=1, SLEEP=2) |
| target_o | output | 2 | Destination mode of the running transition, otherwise the current mode |
| busy_o | output | 1 | A transition latency is running |
| core_clk_en_o | output | 1 | Core clock enable |
| pwr_lvl_o | output | 2 | Power code (2 RUN, 1 IDLE, 0 SLEEP) |

## Verification
The hardest case to reach is a transition that sees conflicting inputs at every cycle of its latency. This must hold on every edge, including the long exit from SLEEP. The bench uses short, distinct latencies. During each transition it holds all four inputs high on every cycle except the last one. It then checks that mode, power code and clock enable stay put until the exact expiry edge. The vector table also drives simultaneous requests to prove the priorities. A reset in the middle of a transition confirms that the counter is abandoned.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_IDLE  = 2'd1,
        MODE_SLEEP = 2'd2
    } pmode_e;

    localparam logic [1:0] PWR_CODE_RUN   = 2'd2;
    localparam logic [1:0] PWR_CODE_IDLE  = 2'd1;
    localparam logic [1:0] PWR_CODE_SLEEP = 2'd0;

    function automatic logic [1:0] pwr_code_of(pmode_e m);
        case (m)
            MODE_RUN:   return PWR_CODE_RUN;
            MODE_IDLE:  return PWR_CODE_IDLE;
            default:    return PWR_CODE_SLEEP;
        endcase
    endfunction

endpackage

// File: rtl/pmc_trans_sel.sv
// Chooses the outgoing edge of the mode graph and its latency.
module pmc_trans_sel
    import pmc_pkg::*;
#(
    parameter int CW             = 4,
    parameter int LAT_RUN_IDLE   = 10,
    parameter int LAT_IDLE_RUN   = 10,
    parameter int LAT_RUN_SLEEP  = 90,
    parameter int LAT_IDLE_SLEEP = 90,
    parameter int LAT_SLEEP_RUN  = 1600
) (
    input  pmode_e          mode_i,
    input  logic            req_idle_i,
    input  logic            req_sleep_i,
    input  logic            irq_i,
    input  logic            wake_i,
    output logic            go_o,
    output pmode_e          dest_o,
    output logic [CW-1:0]   lat_o
);

    always_comb begin
        go_o   = 1'b0;
        dest_o = mode_i;
        lat_o  = '0;
        case (mode_i)
            MODE_RUN: begin
                // R2: sleep request outranks idle request
                if (req_sleep_i) begin
                    go_o   = 1'b1;
                    dest_o = MODE_SLEEP;
                    lat_o  = CW'(LAT_RUN_SLEEP);
                end else if (req_idle_i) begin
                    go_o   = 1'b1;
                    dest_o = MODE_IDLE;
                    lat_o  = CW'(LAT_RUN_IDLE);
                end
            end
            MODE_IDLE: begin
                // R3: interrupt outranks sleep request
                if (irq_i) begin
                    go_o   = 1'b1;
                    dest_o = MODE_RUN;
                    lat_o  = CW'(LAT_IDLE_RUN);
                end else if (req_sleep_i) begin
                    go_o   = 1'b1;
                    dest_o = MODE_SLEEP;
                    lat_o  = CW'(LAT_IDLE_SLEEP);
                end
            end
            default: begin
                // R4: only the wake event leaves SLEEP, and only to RUN
                if (wake_i) begin
                    go_o   = 1'b1;
                    dest_o = MODE_RUN;
                    lat_o  = CW'(LAT_SLEEP_RUN);
                end
            end
        endcase
    end

endmodule

// File: rtl/pmc_lat_timer.sv
// Down-counter that runs a transition latency of lat_i cycles.
module pmc_lat_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] lat_i,
    output logic          busy_o,
    output logic          expire_o
);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.busy) begin
            if (s_q.cnt == '0) begin
                s_d.busy = 1'b0;
            end else begin
                s_d.cnt = s_q.cnt - CW'(1);
            end
        end else if (load_i) begin
            s_d.busy = 1'b1;
            s_d.cnt  = lat_i - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o   = s_q.busy;
    assign expire_o = s_q.busy && (s_q.cnt == '0);

    // R6: a new latency is never started on top of a running one
    a_r6_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !busy_o);

    // R5: the count falls by one on every cycle of a running latency
    a_r5_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && !expire_o) |=> (s_q.busy && s_q.cnt == $past(s_q.cnt) - CW'(1)));

    // R5: the cycle after expiry the timer is free
    a_r5_free_after_expire: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> !busy_o);

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int LAT_RUN_IDLE   = 10,
    parameter int LAT_IDLE_RUN   = 10,
    parameter int LAT_RUN_SLEEP  = 90,
    parameter int LAT_IDLE_SLEEP = 90,
    parameter int LAT_SLEEP_RUN  = 1600
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_idle_i,
    input  logic       req_sleep_i,
    input  logic       irq_i,
    input  logic       wake_i,
    output logic [1:0] mode_o,
    output logic [1:0] target_o,
    output logic       busy_o,
    output logic       core_clk_en_o,
    output logic [1:0] pwr_lvl_o
);

    localparam int LAT_M1  = (LAT_RUN_IDLE > LAT_IDLE_RUN) ? LAT_RUN_IDLE : LAT_IDLE_RUN;
    localparam int LAT_M2  = (LAT_RUN_SLEEP > LAT_IDLE_SLEEP) ? LAT_RUN_SLEEP : LAT_IDLE_SLEEP;
    localparam int LAT_M3  = (LAT_M1 > LAT_M2) ? LAT_M1 : LAT_M2;
    localparam int LAT_MAX = (LAT_M3 > LAT_SLEEP_RUN) ? LAT_M3 : LAT_SLEEP_RUN;
    localparam int CW      = $clog2(LAT_MAX + 1);

    typedef struct packed {
        pmode_e     mode;
        pmode_e     tgt;
        logic       clk_en;
        logic [1:0] pwr;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{mode: MODE_RUN, tgt: MODE_RUN,
                                   clk_en: 1'b1, pwr: PWR_CODE_RUN};

    ctl_t s_d, s_q;

    logic          sel_go;
    pmode_e        sel_dest;
    logic [CW-1:0] sel_lat;
    logic          start;
    logic          tmr_busy;
    logic          tmr_expire;
    logic          busy_next;

    pmc_trans_sel #(
        .CW             (CW),
        .LAT_RUN_IDLE   (LAT_RUN_IDLE),
        .LAT_IDLE_RUN   (LAT_IDLE_RUN),
        .LAT_RUN_SLEEP  (LAT_RUN_SLEEP),
        .LAT_IDLE_SLEEP (LAT_IDLE_SLEEP),
        .LAT_SLEEP_RUN  (LAT_SLEEP_RUN)
    ) i_sel (
        .mode_i      (s_q.mode),
        .req_idle_i  (req_idle_i),
        .req_sleep_i (req_sleep_i),
        .irq_i       (irq_i),
        .wake_i      (wake_i),
        .go_o        (sel_go),
        .dest_o      (sel_dest),
        .lat_o       (sel_lat)
    );

    // R6: requests are taken only when no latency is running
    assign start = sel_go && !tmr_busy;

    pmc_lat_timer #(
        .CW (CW)
    ) i_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (start),
        .lat_i    (sel_lat),
        .busy_o   (tmr_busy),
        .expire_o (tmr_expire)
    );

    assign busy_next = start || (tmr_busy && !tmr_expire);

    always_comb begin
        s_d = s_q;
        if (tmr_expire) begin
            s_d.mode = s_q.tgt;
        end
        if (start) begin
            s_d.tgt = sel_dest;
        end
        s_d.clk_en = (s_d.mode == MODE_RUN) && !busy_next;
        s_d.pwr    = pwr_code_of(s_d.mode);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= CTL_RESET;
        end else begin
            s_q <= s_d;
        end
    end

    assign mode_o        = s_q.mode;
    assign target_o      = s_q.tgt;
    assign busy_o        = tmr_busy;
    assign core_clk_en_o = s_q.clk_en;
    assign pwr_lvl_o     = s_q.pwr;

    // R7: the core clock runs only in a settled RUN mode
    a_r7_clk_en_run_only: assert property (@(posedge clk) disable iff (!rst_n)
        core_clk_en_o |-> (mode_o == MODE_RUN && !busy_o));

    a_r7_clk_en_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_RUN && !busy_o) |-> core_clk_en_o);

    // R6: mode and destination hold while the latency runs
    a_r6_hold_during_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !tmr_expire) |=> ($stable(mode_o) && $stable(target_o) && $stable(pwr_lvl_o)));

    // R5: at expiry the mode becomes the destination
    a_r5_arrive: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_expire |=> (mode_o == $past(target_o)));

    // R8: power code per mode
    a_r8_pwr_run: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_RUN) |-> (pwr_lvl_o == 2'd2));
    a_r8_pwr_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_IDLE) |-> (pwr_lvl_o == 2'd1));
    a_r8_pwr_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_SLEEP) |-> (pwr_lvl_o == 2'd0));

    // R4: SLEEP exits only toward RUN, and nothing but wake starts it
    a_r4_sleep_exit_run: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_SLEEP && busy_o) |-> (target_o == MODE_RUN));
    a_r4_sleep_needs_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_SLEEP && !busy_o && !wake_i) |=> !busy_o);

    // R9: settled mode with no transition shows itself as target
    a_r9_target_settled: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (target_o == mode_o));

endmodule

// File: tb/test_pwr_mode_ctrl.sv
module test_pwr_mode_ctrl;

    localparam int L_RI = 3;
    localparam int L_IR = 2;
    localparam int L_RS = 5;
    localparam int L_IS = 4;
    localparam int L_SR = 9;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_idle = 1'b0;
    logic       req_sleep = 1'b0;
    logic       irq = 1'b0;
    logic       wake = 1'b0;
    logic [1:0] mode;
    logic [1:0] target;
    logic       busy;
    logic       clk_en;
    logic [1:0] pwr;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;
    logic [1:0] cur_mode = 2'd0;

    always #5 clk = ~clk;

    pwr_mode_ctrl #(
        .LAT_RUN_IDLE   (L_RI),
        .LAT_IDLE_RUN   (L_IR),
        .LAT_RUN_SLEEP  (L_RS),
        .LAT_IDLE_SLEEP (L_IS),
        .LAT_SLEEP_RUN  (L_SR)
    ) i_pwr_mode_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_idle_i    (req_idle),
        .req_sleep_i   (req_sleep),
        .irq_i         (irq),
        .wake_i        (wake),
        .mode_o        (mode),
        .target_o      (target),
        .busy_o        (busy),
        .core_clk_en_o (clk_en),
        .pwr_lvl_o     (pwr)
    );

    // stimulus {wake, irq, req_sleep, req_idle}, expected destination, latency (0 = ignored)
    localparam logic [9:0] VEC [12] = '{
        {4'b0001, 2'd1, 4'd3},   // RUN: idle request
        {4'b0001, 2'd1, 4'd0},   // IDLE: idle request ignored
        {4'b1000, 2'd1, 4'd0},   // IDLE: wake ignored
        {4'b0110, 2'd0, 4'd2},   // IDLE: irq beats sleep
        {4'b1000, 2'd0, 4'd0},   // RUN: wake ignored
        {4'b0100, 2'd0, 4'd0},   // RUN: irq ignored
        {4'b0011, 2'd2, 4'd5},   // RUN: sleep beats idle
        {4'b0111, 2'd2, 4'd0},   // SLEEP: irq and requests ignored
        {4'b1000, 2'd0, 4'd9},   // SLEEP: wake to RUN
        {4'b0001, 2'd1, 4'd3},   // RUN: idle request
        {4'b0010, 2'd2, 4'd4},   // IDLE: sleep request
        {4'b1100, 2'd0, 4'd9}    // SLEEP: wake with irq
    };

    function automatic logic [1:0] exp_pwr(input logic [1:0] m);
        case (m)
            2'd0:    return 2'd2;
            2'd1:    return 2'd1;
            default: return 2'd0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic set_in(input logic [3:0] s);
        {wake, irq, req_sleep, req_idle} = s;
    endtask

    task automatic run_vec(input logic [3:0] stim, input logic [1:0] tgt, input int lat);
        logic [1:0] old;
        string      tag;
        old = cur_mode;
        if (old == 2'd0)      tag = "R2";
        else if (old == 2'd1) tag = "R3";
        else                  tag = "R4";
        @(negedge clk);
        set_in(stim);
        @(negedge clk);
        set_in(4'b0000);
        if (lat == 0) begin
            chk(!busy && mode == old, (old == 2'd2) ? "R4 ignored" : "R9 ignored",
                {busy, mode}, {1'b0, old});
        end else begin
            chk(busy && target == tgt && mode == old, {tag, " start"},
                {busy, target, mode}, {1'b1, tgt, old});
            chk(!clk_en, "R7 clk_en off at start", clk_en, 0);
            for (int i = 1; i < lat; i++) begin
                set_in(4'b1111);
                @(negedge clk);
                chk(busy && mode == old && target == tgt && pwr == exp_pwr(old) && !clk_en,
                    "R6 hold", {busy, mode, pwr, clk_en}, {1'b1, old, exp_pwr(old), 1'b0});
            end
            set_in(4'b0000);
            @(negedge clk);
            chk(!busy && mode == tgt, "R5 arrive", {busy, mode}, {1'b0, tgt});
            chk(pwr == exp_pwr(tgt), "R8 power code", pwr, exp_pwr(tgt));
            chk(clk_en == (tgt == 2'd0), "R7 clk_en after", clk_en, (tgt == 2'd0));
            cur_mode = tgt;
        end
    endtask

    initial begin
        repeat (2) @(negedge clk);
        // R1: values while reset is held
        chk(mode == 2'd0 && target == 2'd0 && !busy && clk_en && pwr == 2'd2,
            "R1 in reset", {mode, target, busy, clk_en, pwr}, {4'd0, 1'b0, 1'b1, 2'd2});
        rst_n = 1'b1;
        @(negedge clk);
        chk(mode == 2'd0 && !busy && clk_en && pwr == 2'd2,
            "R1 after reset", {mode, busy, clk_en, pwr}, {2'd0, 1'b0, 1'b1, 2'd2});

        for (int v = 0; v < 12; v++) begin
            run_vec(VEC[v][9:6], VEC[v][5:4], int'(VEC[v][3:0]));
        end

        // R1: reset in the middle of a RUN->SLEEP transition
        @(negedge clk);
        set_in(4'b0010);
        @(negedge clk);
        set_in(4'b0000);
        chk(busy, "R2 busy before reset", busy, 1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (L_RS + 1) @(negedge clk);
        chk(mode == 2'd0 && !busy && clk_en && pwr == 2'd2 && target == 2'd0,
            "R1 reset aborts transition", {mode, busy, clk_en}, {2'd0, 1'b0, 1'b1});
        cur_mode = 2'd0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule